// File: doc/BRIEF.md
# Dual-Address Paged Two-Wire Register Target

This block is an I2C target that keeps its whole register memory in flops and serves it over the two bus wires. Offsets 00h–7Fh are lower memory, which is always visible on the main address. Offsets 80h–FFh form a window. The table number stored in lower-memory byte 7Fh picks which table occupies that window. A 128-byte auxiliary array can be reached in one of two ways. It can sit behind its own fixed bus address. It can instead be folded into the main address as window tables 00h and 01h. A mode bit in the configuration table (table 03h) chooses between these two ways at run time. The main bus address can also be moved to a value stored in that table.

A host writes by sending the address byte, one offset byte and then any number of data bytes. It reads by writing the offset and then issuing a repeated START with the read address. The bus is the only data path. The target never stretches the clock, so it applies no back-pressure. A host that wants to stop reading sends a NACK after the last byte it wants. The block contains an input synchronizer, a bus link engine and the paged storage.

Top module: `i2cpg_target`

## Requirements
- R1: After reset, SDA is released and every stored byte reads 00h. The effective main address is A2h, and both the fold mode and the relocation mode are off.
- R2: The target ACKs its main address in 8-bit write form. In a write transaction, the first byte after the address sets the byte pointer. Each later byte is stored at the pointer, and every byte is ACKed.
- R3: While the fold-mode bit is 0, address A0h reaches a separate 128-byte auxiliary array. Bit 7 of the offset byte is ignored there, and the pointer wraps from 7Fh to 00h.
- R4: An address byte that matches neither active address is NACKed. The rest of that transaction, up to the next START, is ignored and changes nothing.
- R5: Lower memory at 00h–7Fh is ordinary read/write storage on the main address. This includes the table-select byte at 7Fh and the four password-entry bytes at 7Bh–7Eh.
- R6: Table 03h is a 128-byte configuration table in the window. Byte 89h bit 5 is the fold-mode bit. Byte 89h bit 0 is the relocation bit. Byte 8Ch is the relocated main address.
- R7: While fold mode is on, address A0h is NACKed. Tables 00h and 01h both show the same auxiliary bytes in 80h–FFh, and these are the same bytes that A0h reaches when fold mode is off.
- R8: Tables 04h and 05h each hold 72 independent bytes at 80h–C7h. Their bytes C8h–FFh read as 00h, and writes to them are ACKed and discarded.
- R9: Tables 02h, 06h–FFh, and tables 00h/01h while fold mode is off all read as 00h. Writes to them are ACKed and discarded.
- R10: On the main address the pointer steps by one after every data byte. It runs from 7Fh into 80h and wraps from FFh back to 80h.
- R11: With the relocation bit set, the main address is byte 8Ch with bit 0 ignored. With it clear, the main address is A2h. A change to the fold-mode bit, the relocation bit or byte 8Ch takes effect only after the STOP that ends the writing transaction.
- R12: A repeated START keeps the pointer. A read sends bytes from consecutive offsets while the host ACKs them and stops sending after a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus is oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire as seen at the pad |
| sda_i | input | 1 | Bus data wire as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data wire low (open-drain drive) |

## Verification
The bench goes after the points where the address space changes shape. Examples are a write that runs from 7Fh into the window, and a window write that wraps from FFh to 80h. A pointer that did not wrap would store into the wrong table or into lower memory. The bench writes through one alias, tables 00h/01h, and reads back through the other alias and through A0h. A design with two separate arrays would return stale bytes. It also checks that the relocation bit and the fold-mode bit change nothing until the STOP. A design that switched early would NACK the repeated START of the same transaction. Reserved bytes, missing tables and a foreign address are all written and then read back. A design that stored those writes would show them on the readback.

// File: rtl/i2cpg_pkg.sv
package i2cpg_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_WR,
    LK_WACK,
    LK_RD,
    LK_RACK
  } link_st_e;

  localparam logic [7:0] AUX_DEV_ADDR  = 8'hA0;
  localparam logic [7:0] MAIN_DEV_ADDR = 8'hA2;

endpackage

// File: rtl/i2cpg_line_sync.sv
module i2cpg_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int TAPS = SYNC_STAGES + 1;

  logic [TAPS-1:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[TAPS-2:0], scl_i};
      sda_p <= {sda_p[TAPS-2:0], sda_i};
    end
  end

  assign scl_s    = scl_p[SYNC_STAGES-1];
  assign scl_d    = scl_p[SYNC_STAGES];
  assign sda_s    = sda_p[SYNC_STAGES-1];
  assign sda_d    = sda_p[SYNC_STAGES];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock is steadily high mark bus conditions
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cpg_link.sv
module i2cpg_link
  import i2cpg_pkg::*;
#(
  parameter logic [7:0] AUX_DEV  = AUX_DEV_ADDR,
  parameter logic [7:0] MAIN_DEV = MAIN_DEV_ADDR
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  input  logic       cfg_aden,
  input  logic       cfg_adfix,
  input  logic [7:0] cfg_chip,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       aux_sel,
  output logic       mode_aden,
  output logic       wr_en,
  output logic [7:0] wr_data
);
  link_st_e   state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, main_q, ptr_q, ptr_nxt;
  logic       oe_q, rw_q, ofs_done, nack_q, aden_q, aux_q;
  logic       hit_aux, hit_main, byte_done;

  assign hit_aux   = !aden_q && (shreg[7:1] == AUX_DEV[7:1]);
  assign hit_main  = (shreg[7:1] == main_q[7:1]);
  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign ptr_nxt   = aux_q ? {1'b0, ptr_q[6:0] + 7'd1}
                           : ((ptr_q == 8'hFF) ? 8'h80 : ptr_q + 8'd1);

  assign wr_en     = (state == LK_WR) && byte_done && ofs_done;
  assign wr_data   = shreg;
  assign sda_oe    = oe_q;
  assign ptr       = ptr_q;
  assign aux_sel   = aux_q;
  assign mode_aden = aden_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LK_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      ofs_done <= 1'b0;
      nack_q   <= 1'b0;
      aden_q   <= 1'b0;
      aux_q    <= 1'b0;
      ptr_q    <= '0;
      main_q   <= MAIN_DEV;
    end else begin
      if (stop_ev) begin
        main_q <= cfg_adfix ? cfg_chip : MAIN_DEV;
        aden_q <= cfg_aden;
      end
      if (start_ev) begin
        state  <= LK_ADDR;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (stop_ev) begin
        state <= LK_IDLE;
        oe_q  <= 1'b0;
      end else begin
        unique case (state)
          LK_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              if (hit_aux || hit_main) begin
                state    <= LK_AACK;
                oe_q     <= 1'b1;
                rw_q     <= shreg[0];
                aux_q    <= hit_aux;
                ofs_done <= 1'b0;
                if (hit_aux) ptr_q[7] <= 1'b0;
              end else begin
                state <= LK_IDLE;
              end
            end
          end
          LK_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                shreg <= rd_data;
                oe_q  <= ~rd_data[7];
                state <= LK_RD;
              end else begin
                oe_q  <= 1'b0;
                state <= LK_WR;
              end
            end
          end
          LK_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              oe_q  <= 1'b1;
              state <= LK_WACK;
              if (ofs_done) begin
                ptr_q <= ptr_nxt;
              end else begin
                ptr_q    <= aux_q ? {1'b0, shreg[6:0]} : shreg;
                ofs_done <= 1'b1;
              end
            end
          end
          LK_WACK: begin
            if (scl_fall) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              state  <= LK_WR;
            end
          end
          LK_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                oe_q  <= 1'b0;
                state <= LK_RACK;
                ptr_q <= ptr_nxt;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                oe_q  <= ~shreg[6];
              end
            end
          end
          LK_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= LK_IDLE;
              end else begin
                shreg  <= rd_data;
                oe_q   <= ~rd_data[7];
                bitcnt <= '0;
                state  <= LK_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == LK_AACK || state == LK_WACK || state == LK_RD));

  // R3
  aux_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_q && (state == LK_WR || state == LK_WACK || state == LK_RD || state == LK_RACK))
      |-> !ptr_q[7]);

  // R11
  addr_switch_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_q) |-> $past(stop_ev));

  // R4
  foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_ADDR && byte_done && !start_ev && !stop_ev && !hit_aux && !hit_main)
      |=> (state == LK_IDLE && !sda_oe));

endmodule

// File: rtl/i2cpg_store.sv
module i2cpg_store #(
  parameter int         PAGE_BYTES = 128,
  parameter int         LUT_BYTES  = 72,
  parameter int         LUT_TABLES = 2,
  parameter int         LUT_BASE   = 4,
  parameter logic [7:0] CFG_TABLE  = 8'h03,
  parameter int         MODE_IDX   = 9,
  parameter int         CHIP_IDX   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ptr,
  input  logic       aux_sel,
  input  logic       mode_aden,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       cfg_aden,
  output logic       cfg_adfix,
  output logic [7:0] cfg_chip
);
  localparam int IW  = $clog2(PAGE_BYTES);
  localparam int LAW = $clog2(LUT_BYTES);

  logic [7:0] low_q [PAGE_BYTES];
  logic [7:0] aux_q [PAGE_BYTES];
  logic [7:0] cfg_q [PAGE_BYTES];
  logic [IW-1:0]  idx;
  logic [LAW-1:0] idx_l;
  logic [7:0] tsel;
  logic win_on, aux_win, cfg_win, in_lut;
  logic we_low, we_aux, we_cfg;
  logic [LUT_TABLES-1:0] lut_hit, lut_we;
  logic [7:0] lut_rd [LUT_TABLES];

  assign idx     = ptr[IW-1:0];
  assign idx_l   = LAW'(ptr[IW-1:0]);
  assign tsel    = low_q[PAGE_BYTES-1];
  assign win_on  = !aux_sel && ptr[7];
  assign aux_win = win_on && mode_aden && (tsel[7:1] == 7'd0);
  assign cfg_win = win_on && (tsel == CFG_TABLE);
  assign in_lut  = (32'(idx) < LUT_BYTES);
  assign we_low  = wr_en && !aux_sel && !ptr[7];
  assign we_aux  = wr_en && (aux_sel || aux_win);
  assign we_cfg  = wr_en && cfg_win;

  assign cfg_aden  = cfg_q[MODE_IDX][5];
  assign cfg_adfix = cfg_q[MODE_IDX][0];
  assign cfg_chip  = cfg_q[CHIP_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        low_q[i] <= '0;
        aux_q[i] <= '0;
        cfg_q[i] <= '0;
      end
    end else begin
      if (we_low) low_q[idx] <= wr_data;
      if (we_aux) aux_q[idx] <= wr_data;
      if (we_cfg) cfg_q[idx] <= wr_data;
    end
  end

  for (genvar t = 0; t < LUT_TABLES; t++) begin : g_lut
    logic [7:0] mem [LUT_BYTES];
    assign lut_hit[t] = win_on && in_lut && (tsel == 8'(LUT_BASE + t));
    assign lut_we[t]  = wr_en && lut_hit[t];
    assign lut_rd[t]  = mem[idx_l];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LUT_BYTES; i++) mem[i] <= '0;
      end else if (lut_we[t]) begin
        mem[idx_l] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (aux_sel)       rd_data = aux_q[idx];
    else if (!ptr[7])  rd_data = low_q[idx];
    else if (aux_win)  rd_data = aux_q[idx];
    else if (cfg_win)  rd_data = cfg_q[idx];
    else begin
      for (int t = 0; t < LUT_TABLES; t++)
        if (lut_hit[t]) rd_data = lut_rd[t];
    end
  end

  // R8
  one_region_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_low, we_aux, we_cfg, lut_we}));

  // R9
  missing_table_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_on && !aux_win && !cfg_win && lut_hit == '0) |-> (rd_data == 8'h00));

endmodule

// File: rtl/i2cpg_target.sv
module i2cpg_target
  import i2cpg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LUT_BYTES   = 72,
  parameter int LUT_TABLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] ptr, wr_data, rd_data, cfg_chip;
  logic aux_sel, mode_aden, wr_en, cfg_aden, cfg_adfix;

  i2cpg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cpg_link #(.AUX_DEV(AUX_DEV_ADDR), .MAIN_DEV(MAIN_DEV_ADDR)) i_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .rd_data(rd_data), .cfg_aden(cfg_aden), .cfg_adfix(cfg_adfix),
    .cfg_chip(cfg_chip), .sda_oe(sda_oe_o), .ptr(ptr), .aux_sel(aux_sel),
    .mode_aden(mode_aden), .wr_en(wr_en), .wr_data(wr_data)
  );

  i2cpg_store #(.LUT_BYTES(LUT_BYTES), .LUT_TABLES(LUT_TABLES)) i_store (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .aux_sel(aux_sel),
    .mode_aden(mode_aden), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_aden(cfg_aden), .cfg_adfix(cfg_adfix),
    .cfg_chip(cfg_chip)
  );

endmodule

// File: tb/test_i2cpg_target.sv
module test_i2cpg_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  i2cpg_target i_i2cpg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  // bench model of the requirements
  logic [7:0] m_low [128];
  logic [7:0] m_aux [128];
  logic [7:0] m_cfg [128];
  logic [7:0] m_lut [2][72];
  bit         m_aden = 1'b0;
  logic [7:0] m_main = 8'hA2;
  logic [7:0] m_ptr = 8'h00;
  bit         m_auxsel = 1'b0;
  logic [7:0] wbuf [8];

  function automatic bit m_hit_aux(input logic [7:0] dev);
    return !m_aden && (dev[7:1] == 7'h50);
  endfunction

  function automatic bit m_hit(input logic [7:0] dev);
    return m_hit_aux(dev) || (dev[7:1] == m_main[7:1]);
  endfunction

  function automatic logic [7:0] m_rd(input bit a, input logic [7:0] p);
    logic [7:0] t;
    t = m_low[127];
    if (a) return m_aux[p[6:0]];
    if (!p[7]) return m_low[p[6:0]];
    if (t <= 8'd1) return m_aden ? m_aux[p[6:0]] : 8'h00;
    if (t == 8'd3) return m_cfg[p[6:0]];
    if ((t == 8'd4 || t == 8'd5) && p <= 8'hC7) return m_lut[t - 8'd4][p - 8'h80];
    return 8'h00;
  endfunction

  task automatic m_wr(input bit a, input logic [7:0] p, input logic [7:0] d);
    logic [7:0] t;
    t = m_low[127];
    if (a) m_aux[p[6:0]] = d;
    else if (!p[7]) m_low[p[6:0]] = d;
    else if (t <= 8'd1) begin if (m_aden) m_aux[p[6:0]] = d; end
    else if (t == 8'd3) m_cfg[p[6:0]] = d;
    else if ((t == 8'd4 || t == 8'd5) && p <= 8'hC7) m_lut[t - 8'd4][p - 8'h80] = d;
  endtask

  function automatic logic [7:0] m_next(input bit a, input logic [7:0] p);
    if (a) return {1'b0, p[6:0] + 7'd1};
    return (p == 8'hFF) ? 8'h80 : p + 8'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // bus primitives
  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); sda_m = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; hold(); scl = 1'b1; hold(); scl = 1'b0; hold();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); b = sda_line; scl = 1'b0; hold();
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(nack);
  endtask

  // transaction steps with model tracking
  task automatic t_addr(input logic [7:0] dev, input string req, output bit ack);
    bit exp;
    exp = m_hit(dev);
    put_byte(dev, ack);
    chk(ack == exp, req, int'(ack), int'(exp));
    if (ack) begin
      m_auxsel = m_hit_aux(dev);
      if (m_auxsel) m_ptr[7] = 1'b0;
    end
  endtask

  task automatic t_ofs(input logic [7:0] o, input string req);
    bit ack;
    put_byte(o, ack);
    chk(ack, req, int'(ack), 1);
    m_ptr = m_auxsel ? {1'b0, o[6:0]} : o;
  endtask

  task automatic t_wr(input logic [7:0] d, input string req);
    bit ack;
    put_byte(d, ack);
    chk(ack, req, int'(ack), 1);
    m_wr(m_auxsel, m_ptr, d);
    m_ptr = m_next(m_auxsel, m_ptr);
  endtask

  task automatic t_rd(input bit last, input string req);
    logic [7:0] d, e;
    e = m_rd(m_auxsel, m_ptr);
    get_byte(last, d);
    chk(d == e, req, int'(d), int'(e));
    m_ptr = m_next(m_auxsel, m_ptr);
  endtask

  task automatic t_stop();
    bus_stop();
    m_aden = m_cfg[9][5];
    m_main = m_cfg[9][0] ? m_cfg[12] : 8'hA2;
  endtask

  task automatic t_write(input logic [7:0] dev, input logic [7:0] ofs, input int n,
                         input string req);
    bit ack, a2;
    bus_start();
    t_addr(dev, req, ack);
    if (ack) begin
      t_ofs(ofs, req);
      for (int k = 0; k < n; k++) t_wr(wbuf[k], req);
    end else begin
      // R4: keep clocking bytes after the NACK; all must stay unanswered
      put_byte(ofs, a2);
      chk(!a2, "R4", int'(a2), 0);
      for (int k = 0; k < n; k++) begin
        put_byte(wbuf[k], a2);
        chk(!a2, "R4", int'(a2), 0);
      end
    end
    t_stop();
  endtask

  task automatic t_read(input logic [7:0] dev, input logic [7:0] ofs, input int n,
                        input string req);
    bit ack;
    bus_start();
    t_addr(dev, req, ack);
    t_ofs(ofs, req);
    bus_start();
    t_addr(dev | 8'h01, req, ack);
    for (int k = 0; k < n; k++) t_rd(k == n - 1, req);
    t_stop();
  endtask

  task automatic set1(input logic [7:0] dev, input logic [7:0] ofs, input logic [7:0] v,
                      input string req);
    wbuf[0] = v;
    t_write(dev, ofs, 1, req);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin m_low[i] = 0; m_aux[i] = 0; m_cfg[i] = 0; end
    for (int t = 0; t < 2; t++) for (int i = 0; i < 72; i++) m_lut[t][i] = 0;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released bus and zeroed storage after reset
    chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
    t_read(8'hA2, 8'h00, 2, "R1");

    // R5: password bytes and ordinary lower memory
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    t_write(8'hA2, 8'h7B, 4, "R5");
    t_read(8'hA2, 8'h7B, 4, "R5");

    // R3: auxiliary array, 7Fh to 00h wrap, offset bit 7 ignored
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    t_write(8'hA0, 8'h7E, 3, "R3");
    t_read(8'hA0, 8'h7F, 2, "R3");
    set1(8'hA0, 8'h85, 8'h5C, "R3");
    t_read(8'hA0, 8'h05, 1, "R3");

    // R4: foreign address NACKed and its bytes dropped
    wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
    t_write(8'hA4, 8'h7B, 2, "R4");
    t_read(8'hA2, 8'h7B, 2, "R4");

    // R10: lower memory runs into the window (7Fh := 04h, then table 04h byte 80h)
    wbuf[0] = 8'h66; wbuf[1] = 8'h04; wbuf[2] = 8'h77;
    t_write(8'hA2, 8'h7E, 3, "R10");
    t_read(8'hA2, 8'h80, 1, "R10");

    // R8: table 04h edge and reserved bytes, table 05h independent
    wbuf[0] = 8'h31; wbuf[1] = 8'h32; wbuf[2] = 8'h33;
    t_write(8'hA2, 8'hC6, 3, "R8");
    t_read(8'hA2, 8'hC6, 3, "R8");
    set1(8'hA2, 8'h7F, 8'h05, "R8");
    t_read(8'hA2, 8'hC6, 2, "R8");
    set1(8'hA2, 8'hFF, 8'h99, "R8");
    t_read(8'hA2, 8'hFF, 1, "R8");

    // R9: missing tables
    set1(8'hA2, 8'h7F, 8'h02, "R9");
    set1(8'hA2, 8'h90, 8'h55, "R9");
    t_read(8'hA2, 8'h90, 1, "R9");
    set1(8'hA2, 8'h7F, 8'h00, "R9");
    set1(8'hA2, 8'h81, 8'h56, "R9");
    t_read(8'hA2, 8'h81, 1, "R9");
    t_read(8'hA0, 8'h01, 1, "R9");
    set1(8'hA2, 8'h7F, 8'hC3, "R9");
    t_read(8'hA2, 8'hA0, 1, "R9");

    // R6 and R10: configuration table and FFh to 80h wrap
    set1(8'hA2, 8'h7F, 8'h03, "R6");
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5; wbuf[2] = 8'h3E;
    t_write(8'hA2, 8'hFE, 3, "R10");
    t_read(8'hA2, 8'hFF, 2, "R10");
    set1(8'hA2, 8'hA0, 8'hC9, "R6");
    t_read(8'hA2, 8'hA0, 1, "R6");

    // R7: fold mode, A0h refused, tables 00h/01h alias the auxiliary array
    set1(8'hA2, 8'h89, 8'h20, "R7");
    set1(8'hA0, 8'h10, 8'h01, "R7");
    set1(8'hA2, 8'h7F, 8'h00, "R7");
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    t_write(8'hA2, 8'h90, 2, "R7");
    set1(8'hA2, 8'h7F, 8'h01, "R7");
    t_read(8'hA2, 8'h90, 2, "R7");
    t_read(8'hA2, 8'h85, 1, "R7");
    set1(8'hA2, 8'h7F, 8'h03, "R7");
    set1(8'hA2, 8'h89, 8'h00, "R7");
    t_read(8'hA0, 8'h10, 2, "R7");

    // R11: relocation becomes active only after the STOP
    set1(8'hA2, 8'h8C, 8'h3C, "R11");
    begin
      bit ack;
      bus_start();
      t_addr(8'hA2, "R11", ack);
      t_ofs(8'h89, "R11");
      t_wr(8'h01, "R11");
      bus_start();
      t_addr(8'hA3, "R11", ack);
      t_rd(1'b1, "R11");
      t_stop();
    end
    set1(8'hA2, 8'h20, 8'h12, "R11");
    t_read(8'h3C, 8'h8C, 1, "R11");
    set1(8'h3C, 8'h89, 8'h00, "R11");
    t_read(8'hA2, 8'h89, 1, "R11");

    // R2 / R12: random bursts, random reads via repeated START
    for (int it = 0; it < 16; it++) begin
      logic [7:0] o;
      int n;
      n = int'($urandom_range(1, 3));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      if (it < 8) begin
        o = 8'($urandom_range(0, 8'h78));
      end else begin
        set1(8'hA2, 8'h7F, 8'(4 + (it % 2)), "R2");
        o = 8'($urandom_range(8'h80, 8'hC5));
      end
      t_write(8'hA2, o, n, "R2");
      t_read(8'hA2, o, n, "R12");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule